// File: doc/BRIEF.md
# Interleaved Cyclic Shift-Accumulate Engine

This block is the arithmetic core of an encoder for quasi-cyclic parity-check codes. Each operation takes a Z-bit subvector and a rotate amount. A cascade of conditional power-of-two stages rotates the subvector cyclically. The rotated word is then either loaded into, or XORed into, a running sum held for one of four frames.

The four frames share the engine in fixed time slots: 0, 1, 2, 3, 0, ... counted from reset. Every cycle belongs to exactly one frame's slot, whether or not it carries an operation. Each frame's partial sum returns to the accumulate stage through a delay line that is exactly as deep as the slot rotation. The datapath can therefore be pipelined. Seen from one frame, each operation still builds directly on that frame's previous result.

A sequencer outside this block chooses the operands and decides when to clear. It must present each frame's operation in that frame's slot.

Top module: `qc_shift_accum`

## Requirements
- R1: After reset `outValid` is low. Every frame's running sum is zero, so a first non-clearing operation returns only its rotated operand.
- R2: Rotation is right-cyclic. Rotated bit i equals operand bit (i + inShift) mod Z, and inShift = 0 passes the operand unchanged.
- R3: An operation with `inClear` high replaces its frame's sum with the rotated operand.
- R4: An operation with `inClear` low replaces its frame's sum with the old sum XOR the rotated operand.
- R5: Each frame's sum is changed only by operations carrying that frame's tag.
- R6: The result of an operation accepted on a rising edge appears with `outValid` high on the second rising edge after it. `outTag` equals the operation's tag and `outData` equals the frame's new sum.
- R7: A slot with `inValid` low leaves that frame's sum unchanged and produces no output.
- R8: Slots rotate 0, 1, 2, 3 starting at the first edge after reset, one per clock. Whenever `inValid` is high, `inTag` must equal the current slot.
- R9: Every rotate amount from 0 to Z-1 is honoured, including the largest, Z-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation present in this slot |
| inData | input | Z | Subvector to rotate |
| inShift | input | log2(Z) | Right-cyclic rotate amount |
| inClear | input | 1 | 1 = load the rotated word, 0 = XOR it into the sum |
| inTag | input | log2(FRAMES) | Frame of the operation; must match the slot |
| outValid | output | 1 | Result present |
| outData | output | Z | Frame's updated sum |
| outTag | output | log2(FRAMES) | Frame of the result |

## Verification
The bench builds the engine with its defaults, Z = 64 and four frames. The full six-stage rotator is therefore present, and the top rotate amount of 63 can be driven. Walking single-bit operands at a range of rotate amounts pin down direction and wrap-around. Clear and accumulate rounds, and rounds with idle slots for some frames, show that each frame's sum travels the four-deep feedback loop intact and is never touched by a neighbour.

// File: rtl/qc_shift_accum_pkg.sv
package qc_shift_accum_pkg;
  // Strobes passed from the slot control to the datapath
  typedef struct packed {
    logic loadIn;    // capture operand and rotate amount
    logic loadRot;   // capture rotated word
    logic accEn;     // accumulate stage holds a live operation
    logic accClear;  // live operation replaces the sum
  } ctrlStrobes_t;
endpackage

// File: rtl/qc_shift_accum_ctrl.sv
module qc_shift_accum_ctrl
  import qc_shift_accum_pkg::*;
#(
  parameter int FRAMES = 4,
  localparam int TAG_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inClear,
  input  logic [TAG_W-1:0] inTag,
  output ctrlStrobes_t     strobes,
  output logic             outValid,
  output logic [TAG_W-1:0] outTag
);
  logic             validA, clearA, validB, clearB;
  logic [TAG_W-1:0] tagA, tagB;

  always_ff @(posedge clk) begin
    if (rst) begin
      validA   <= 1'b0;
      clearA   <= 1'b0;
      tagA     <= '0;
      validB   <= 1'b0;
      clearB   <= 1'b0;
      tagB     <= '0;
      outValid <= 1'b0;
      outTag   <= '0;
    end else begin
      validA   <= inValid;
      clearA   <= inClear & inValid;
      tagA     <= inTag;
      validB   <= validA;
      clearB   <= clearA;
      tagB     <= tagA;
      outValid <= validB;
      outTag   <= tagB;
    end
  end

  always_comb begin
    strobes.loadIn   = inValid;
    strobes.loadRot  = validA;
    strobes.accEn    = validB;
    strobes.accClear = clearB;
  end
endmodule

// File: rtl/qc_shift_accum_dp.sv
module qc_shift_accum_dp
  import qc_shift_accum_pkg::*;
#(
  parameter int Z      = 64,
  parameter int FRAMES = 4,
  localparam int SHIFT_W = $clog2(Z),
  localparam int DLY_N   = FRAMES - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [Z-1:0]       inData,
  input  logic [SHIFT_W-1:0] inShift,
  output logic [Z-1:0]       sumOut
);
  logic [Z-1:0]       dataA;
  logic [SHIFT_W-1:0] shiftA;
  logic [Z-1:0]       rotB;
  logic [Z-1:0]       stage [SHIFT_W+1];
  logic [Z-1:0]       dly   [DLY_N];
  logic [Z-1:0]       feedback;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataA  <= '0;
      shiftA <= '0;
    end else if (strobes.loadIn) begin
      dataA  <= inData;
      shiftA <= inShift;
    end
  end

  // Rotate chain: stage k optionally rotates right by 2^k
  assign stage[0] = dataA;
  for (genvar k = 0; k < SHIFT_W; k++) begin : g_rot
    localparam int AMT = 1 << k;
    assign stage[k+1] = shiftA[k] ? {stage[k][AMT-1:0], stage[k][Z-1:AMT]}
                                  : stage[k];
  end

  always_ff @(posedge clk) begin
    if (rst)                  rotB <= '0;
    else if (strobes.loadRot) rotB <= stage[SHIFT_W];
  end

  // Accumulate stage; idle slots recirculate the sum unchanged
  assign feedback = dly[DLY_N-1];

  always_ff @(posedge clk) begin
    if (rst)                   sumOut <= '0;
    else if (!strobes.accEn)   sumOut <= feedback;
    else if (strobes.accClear) sumOut <= rotB;
    else                       sumOut <= rotB ^ feedback;
  end

  // Delay line closing the loop to one full slot rotation
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DLY_N; i++) dly[i] <= '0;
    end else begin
      dly[0] <= sumOut;
      for (int i = 1; i < DLY_N; i++) dly[i] <= dly[i-1];
    end
  end
endmodule

// File: rtl/qc_shift_accum.sv
module qc_shift_accum
  import qc_shift_accum_pkg::*;
#(
  parameter int Z      = 64,
  parameter int FRAMES = 4,
  localparam int SHIFT_W = $clog2(Z),
  localparam int TAG_W   = $clog2(FRAMES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [Z-1:0]       inData,
  input  logic [SHIFT_W-1:0] inShift,
  input  logic               inClear,
  input  logic [TAG_W-1:0]   inTag,
  output logic               outValid,
  output logic [Z-1:0]       outData,
  output logic [TAG_W-1:0]   outTag
);
  ctrlStrobes_t strobes;

  qc_shift_accum_ctrl #(.FRAMES(FRAMES)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inClear(inClear),
    .inTag(inTag), .strobes(strobes), .outValid(outValid), .outTag(outTag)
  );

  qc_shift_accum_dp #(.Z(Z), .FRAMES(FRAMES)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .inData(inData),
    .inShift(inShift), .sumOut(outData)
  );
endmodule

// File: rtl/qc_shift_accum_chk.sv
module qc_shift_accum_chk #(
  parameter int Z      = 64,
  parameter int FRAMES = 4,
  localparam int SHIFT_W = $clog2(Z),
  localparam int TAG_W   = $clog2(FRAMES)
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [Z-1:0]       inData,
  input logic [SHIFT_W-1:0] inShift,
  input logic               inClear,
  input logic [TAG_W-1:0]   inTag,
  input logic               outValid,
  input logic [Z-1:0]       outData,
  input logic [TAG_W-1:0]   outTag
);
  logic [1:0]       warmCnt;
  logic [TAG_W-1:0] slot;
  logic             warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      warmCnt <= '0;
      slot    <= '0;
    end else begin
      if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
      slot <= (int'(slot) == FRAMES - 1) ? '0 : slot + 1'b1;
    end
  end
  assign warm = (warmCnt == 2'd3);

  function automatic logic [Z-1:0] refRot(input logic [Z-1:0] d,
                                          input logic [SHIFT_W-1:0] s);
    logic [Z-1:0] r;
    for (int i = 0; i < Z; i++) r[i] = d[(i + int'(s)) % Z];
    return r;
  endfunction

  // R8: operations arrive in their own slot
  p_slot_order_r8: assert property (@(posedge clk) disable iff (rst)
    inValid |-> inTag == slot);

  // R6: results emerge exactly two edges after capture
  p_valid_latency_r6: assert property (@(posedge clk) disable iff (rst)
    warm |-> outValid == $past(inValid, 3));

  // R6: result carries the operation's frame
  p_tag_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (warm && outValid) |-> outTag == $past(inTag, 3));

  // R3: clearing operation yields the bare rotated operand
  p_clear_load_r3: assert property (@(posedge clk) disable iff (rst)
    (warm && outValid && $past(inClear, 3)) |->
      outData == refRot($past(inData, 3), $past(inShift, 3)));
endmodule

bind qc_shift_accum qc_shift_accum_chk #(.Z(Z), .FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
  .inShift(inShift), .inClear(inClear), .inTag(inTag),
  .outValid(outValid), .outData(outData), .outTag(outTag)
);

// File: tb/qc_shift_accum_bench.sv
module qc_shift_accum_bench;
  localparam int Z       = 64;
  localparam int FRAMES  = 4;
  localparam int SHIFT_W = $clog2(Z);
  localparam int TAG_W   = $clog2(FRAMES);

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               inValid = 1'b0;
  logic [Z-1:0]       inData = '0;
  logic [SHIFT_W-1:0] inShift = '0;
  logic               inClear = 1'b0;
  logic [TAG_W-1:0]   inTag = '0;
  logic               outValid;
  logic [Z-1:0]       outData;
  logic [TAG_W-1:0]   outTag;

  qc_shift_accum u_qc_shift_accum (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [Z-1:0]     data;
    logic [TAG_W-1:0] tag;
    int               due;
    string            req;
  } expItem_t;

  expItem_t     expQ[$];
  logic [Z-1:0] model [FRAMES];
  int           checks = 0, errors = 0, cyc = 0, bSlot = 0;
  bit           done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [Z-1:0] rotR(input logic [Z-1:0] d, input int s);
    logic [Z-1:0] r;
    for (int i = 0; i < Z; i++) r[i] = d[(i + s) % Z];
    return r;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver: called at a falling edge; drives one slot, then waits one clock
  task automatic drive(input bit v, input bit clr, input logic [Z-1:0] d,
                       input int s, input string req);
    expItem_t it;
    inValid = v; inClear = clr; inData = d;
    inShift = s[SHIFT_W-1:0]; inTag = bSlot[TAG_W-1:0];
    if (v) begin
      model[bSlot] = clr ? rotR(d, s) : (model[bSlot] ^ rotR(d, s));
      it.data = model[bSlot]; it.tag = bSlot[TAG_W-1:0];
      it.due = cyc + 3; it.req = req;
      expQ.push_back(it);
    end
    bSlot = (bSlot + 1) % FRAMES;
    @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && outValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R7: unexpected output tag %0d data %h, expected none",
                 outTag, outData);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (outData !== e.data || outTag !== e.tag || cyc != e.due) begin
          errors++;
          $display("FAIL %s/R6: got tag %0d data %h cycle %0d, expected tag %0d data %h cycle %0d",
                   e.req, outTag, outData, cyc, e.tag, e.data, e.due);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    for (int f = 0; f < FRAMES; f++) model[f] = '0;
    repeat (3) @(negedge clk);
    // R1: output idle while in reset
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: outValid %b in reset, expected 0", outValid);
    end
    rst = 1'b0;
    // R1/R2: first non-clearing ops see zero sums; walking bits probe direction
    drive(1, 0, 64'h1, 0, "R1");
    drive(1, 0, 64'h1, 1, "R2");
    drive(1, 0, 64'h8000_0000_0000_0000, 5, "R2");
    drive(1, 0, 64'h0000_0000_0001_0000, 17, "R2");
    // R3/R9: clear with assorted amounts including Z-1
    drive(1, 1, 64'hDEAD_BEEF_0123_4567, 63, "R9");
    drive(1, 1, 64'h0F0F_0000_FFFF_1234, 32, "R3");
    drive(1, 1, 64'h8000_0000_0000_0001, 63, "R9");
    drive(1, 1, 64'hA5A5_5A5A_C3C3_3C3C, 0, "R3");
    // R4/R5: accumulate rounds with varied operands
    for (int r = 0; r < 6; r++)
      for (int f = 0; f < FRAMES; f++)
        drive(1, 0, {$urandom, $urandom}, (r * 11 + f * 7) % Z, "R4");
    // R7: frames 1 and 3 idle for two rounds, then a fully idle round
    for (int r = 0; r < 2; r++)
      for (int f = 0; f < FRAMES; f++)
        drive(f % 2 == 0, 0, {$urandom, $urandom}, (r * 5 + f) % Z, "R5");
    for (int f = 0; f < FRAMES; f++) drive(0, 0, '0, 0, "R7");
    for (int f = 0; f < FRAMES; f++)
      drive(1, 0, {$urandom, $urandom}, (f * 13 + 3) % Z, "R7");
    // R2/R9: every amount exercised in a clear/accumulate mix
    for (int s = 0; s < Z; s++)
      drive(1, (s % 3) == 0, 64'h1 << (s % Z) | 64'h3, s, "R9");
    for (int f = 0; f < FRAMES; f++) drive(0, 0, '0, 0, "R7");
    repeat (6) @(negedge clk);
    // R6: every queued result must have been delivered
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R6: %0d results outstanding, expected 0", expQ.size());
    end
    finishRun();
  end
endmodule